// File: doc/BRIEF.md
# Load-Locked / Store-Conditional Reservation Monitor

This block sits beside one processor's memory pipeline and handles physical load and conditional-store accesses. A load forms its address from a base register and a signed 12-bit displacement, reads a longword or quadword through a simple memory port, and returns the value. Longword results are sign-extended to 64 bits. A locked load also records the address and the returned value as the processor's single reservation.

A conditional store looks at that reservation. With no reservation it neither reads nor writes memory and returns status 0. With a reservation for the same address it reads memory first. It writes only if memory still holds the captured value, so it acts as a compare-and-swap. With a reservation for another address it writes at once. Either kind of conditional store consumes the reservation. A snooped write seen elsewhere in the system clears the reservation through a dedicated input.

The memory port uses a request/ready handshake. One request is outstanding at a time, and a compare-and-swap issues a read phase before its write phase. The result appears on a one-cycle done pulse in the cycle after the final ready.

Top module: `llsc_monitor`

## Requirements
- R1: The access address on mem_addr_o is req_base_i plus req_disp_i sign-extended from 12 bits (for example, displacement 12'hFF8 subtracts 8).
- R2: A load with req_fn_i bit 0 = 0 (longword) returns bits 31:0 of the read word sign-extended to 64 bits. With bit 0 = 1 (quadword) it returns all 64 bits.
- R3: A load with req_fn_i bit 1 = 1 (locked) records the address and the returned value as the reservation. A load with bit 1 = 0 leaves no reservation behind.
- R4: A conditional store (req_store_i = 1) with no reservation makes no memory request and returns status 0.
- R5: A conditional store to the reserved address reads memory first. It writes req_wdata_i and returns 1 if the read value equals the captured value. Otherwise it returns 0 and does not write.
- R6: For a longword conditional store (req_fn_i bit 0 = 0), the comparison covers only bits 31:0. The write is issued with mem_quad_o = 0, so only the low 32 bits of memory change.
- R7: A conditional store to a different address while a reservation is held writes without a read phase and returns status 1.
- R8: Every conditional store clears the reservation, whether it succeeds or fails.
- R9: A one-cycle pulse on snoop_inv_i clears the reservation, so a later conditional store returns 0 and does not write.
- R10: While mem_req_o is high and mem_ready_i is low, the request and its address stay stable. done_o is a one-cycle pulse. A write accepted by ready is followed by done_o with status 1 in the next cycle. busy_o is high from the cycle after acceptance until done_o.
- R11: After reset the block is idle, holds no reservation, drives no memory request and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Operation request, taken when busy_o is low |
| req_store_i | input | 1 | 1 = conditional store, 0 = load |
| req_fn_i | input | 2 | Bit 0: quadword; bit 1: locked (loads) |
| req_base_i | input | 64 | Base register value |
| req_disp_i | input | 12 | Signed displacement |
| req_wdata_i | input | 64 | Store data |
| busy_o | output | 1 | Operation in progress |
| snoop_inv_i | input | 1 | Clears the reservation |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_quad_o | output | 1 | 1 = 64-bit access, 0 = low 32 bits |
| mem_addr_o | output | 64 | Access address |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Completes the current request |
| done_o | output | 1 | Result valid pulse |
| done_data_o | output | 64 | Load value or store status |

## Verification
The hardest case to reach from the ports is a same-address conditional store whose comparison fails. Memory must change between the locked load and the store without this block writing it. The bench's memory model plays the other agent: it overwrites the reserved word directly between the two operations. It also changes only the upper half of a word under a longword reservation, to show that the narrow comparison still succeeds. Snoop invalidation and the different-address path are driven in the same window, with read and write counts taken around each operation.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_DONE
  } llsc_state_e;
endpackage

// File: rtl/llsc_agu.sv
module llsc_agu #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 12
) (
  input  logic [XLEN-1:0]   base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [XLEN-1:0]   ea_o
);
  localparam int EXT_W = XLEN - DISP_W;
  logic [XLEN-1:0] disp_sx;

  assign disp_sx = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign ea_o    = base_i + disp_sx;
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic [XLEN-1:0] set_addr_i,
  input  logic [XLEN-1:0] set_data_i,
  input  logic            consume_i,
  input  logic            inv_i,
  output logic            valid_o,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] data_o
);
  logic            valid_q;
  logic [XLEN-1:0] addr_q, data_q;

  // a snoop in the same cycle as a new reservation wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (inv_i || consume_i) valid_q <= 1'b0;
      else if (set_i)         valid_q <= 1'b1;
      if (set_i) begin
        addr_q <= set_addr_i;
        data_q <= set_data_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
endmodule

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
  import llsc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            req_store_i,
  input  logic [1:0]      req_fn_i,
  input  logic [XLEN-1:0] ea_i,
  input  logic [XLEN-1:0] req_wdata_i,
  output logic            busy_o,
  input  logic            resv_valid_i,
  input  logic [XLEN-1:0] resv_addr_i,
  input  logic [XLEN-1:0] resv_data_i,
  output logic            resv_set_o,
  output logic [XLEN-1:0] resv_addr_o,
  output logic [XLEN-1:0] resv_data_o,
  output logic            resv_consume_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic            mem_quad_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic            mem_ready_i,
  output logic            done_o,
  output logic [XLEN-1:0] done_data_o
);
  localparam int WORD_W = XLEN / 2;

  llsc_state_e     state_q, state_d;
  logic [XLEN-1:0] addr_q, wdata_q, cmp_q, res_q, res_d;
  logic            quad_q, lock_q, store_q;
  logic            accept, addr_hit, cmp_ok;
  logic [XLEN-1:0] ld_val;

  assign accept   = req_valid_i && (state_q == ST_IDLE);
  assign addr_hit = (resv_addr_i == ea_i);
  assign ld_val   = quad_q ? mem_rdata_i
                           : {{WORD_W{mem_rdata_i[WORD_W-1]}}, mem_rdata_i[WORD_W-1:0]};
  assign cmp_ok   = quad_q ? (mem_rdata_i == cmp_q)
                           : (mem_rdata_i[WORD_W-1:0] == cmp_q[WORD_W-1:0]);

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        if (!req_store_i)       state_d = ST_RD;
        else if (!resv_valid_i) begin
          state_d = ST_DONE;
          res_d   = '0;
        end
        else if (addr_hit)      state_d = ST_RD;
        else                    state_d = ST_WR;
      end
      ST_RD: if (mem_ready_i) begin
        if (!store_q) begin
          state_d = ST_DONE;
          res_d   = ld_val;
        end else if (cmp_ok) begin
          state_d = ST_WR;
        end else begin
          state_d = ST_DONE;
          res_d   = '0;
        end
      end
      ST_WR: if (mem_ready_i) begin
        state_d = ST_DONE;
        res_d   = XLEN'(1);
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      cmp_q   <= '0;
      res_q   <= '0;
      quad_q  <= 1'b0;
      lock_q  <= 1'b0;
      store_q <= 1'b0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      if (accept) begin
        addr_q  <= ea_i;
        wdata_q <= req_wdata_i;
        cmp_q   <= resv_data_i;
        quad_q  <= req_fn_i[0];
        lock_q  <= req_fn_i[1];
        store_q <= req_store_i;
      end
    end
  end

  assign busy_o         = (state_q != ST_IDLE);
  assign resv_set_o     = (state_q == ST_RD) && mem_ready_i && !store_q && lock_q;
  assign resv_addr_o    = addr_q;
  assign resv_data_o    = ld_val;
  assign resv_consume_o = accept && req_store_i;
  assign mem_req_o      = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o       = (state_q == ST_WR);
  assign mem_quad_o     = quad_q;
  assign mem_addr_o     = addr_q;
  assign mem_wdata_o    = quad_q ? wdata_q : {{WORD_W{1'b0}}, wdata_q[WORD_W-1:0]};
  assign done_o         = (state_q == ST_DONE);
  assign done_data_o    = res_q;
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int XLEN   = 64,
  parameter int DISP_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [1:0]        req_fn_i,
  input  logic [XLEN-1:0]   req_base_i,
  input  logic [DISP_W-1:0] req_disp_i,
  input  logic [XLEN-1:0]   req_wdata_i,
  output logic              busy_o,
  input  logic              snoop_inv_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_quad_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  input  logic [XLEN-1:0]   mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              done_o,
  output logic [XLEN-1:0]   done_data_o
);
  logic [XLEN-1:0] ea;
  logic            rv_valid, rv_set, rv_consume;
  logic [XLEN-1:0] rv_addr, rv_data, rv_set_addr, rv_set_data;

  llsc_agu #(.XLEN(XLEN), .DISP_W(DISP_W)) agu_i (
    .base_i (req_base_i),
    .disp_i (req_disp_i),
    .ea_o   (ea)
  );

  llsc_resv #(.XLEN(XLEN)) resv_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (rv_set),
    .set_addr_i (rv_set_addr),
    .set_data_i (rv_set_data),
    .consume_i  (rv_consume),
    .inv_i      (snoop_inv_i),
    .valid_o    (rv_valid),
    .addr_o     (rv_addr),
    .data_o     (rv_data)
  );

  llsc_ctrl #(.XLEN(XLEN)) ctrl_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_store_i    (req_store_i),
    .req_fn_i       (req_fn_i),
    .ea_i           (ea),
    .req_wdata_i    (req_wdata_i),
    .busy_o         (busy_o),
    .resv_valid_i   (rv_valid),
    .resv_addr_i    (rv_addr),
    .resv_data_i    (rv_data),
    .resv_set_o     (rv_set),
    .resv_addr_o    (rv_set_addr),
    .resv_data_o    (rv_set_data),
    .resv_consume_o (rv_consume),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .mem_quad_o     (mem_quad_o),
    .mem_addr_o     (mem_addr_o),
    .mem_wdata_o    (mem_wdata_o),
    .mem_rdata_i    (mem_rdata_i),
    .mem_ready_i    (mem_ready_i),
    .done_o         (done_o),
    .done_data_o    (done_data_o)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_store_i,
  input logic            busy_o,
  input logic            mem_req_o,
  input logic            mem_we_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            mem_ready_i,
  input logic            done_o,
  input logic [XLEN-1:0] done_data_o
);
  logic store_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     store_q <= 1'b0;
    else if (req_valid_i && !busy_o) store_q <= req_store_i;
  end

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_write_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_ready_i |=> done_o && (done_data_o == XLEN'(1)));

  assert_busy_after_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o |=> busy_o);

  // R5, R7: conditional store status is 0 or 1
  assert_status_binary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && store_q |-> done_data_o[XLEN-1:1] == '0);

  assert_idle_no_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !done_o);
endmodule

bind llsc_monitor llsc_monitor_chk #(.XLEN(XLEN)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_store_i (req_store_i),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ready_i (mem_ready_i),
  .done_o      (done_o),
  .done_data_o (done_data_o)
);

// File: tb/llsc_monitor_tb_top.sv
`timescale 1ns/1ps
module llsc_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, snoop = 1'b0;
  logic [1:0]  req_fn = '0;
  logic [63:0] req_base = '0, req_wdata = '0;
  logic [11:0] req_disp = '0;
  logic        busy, mem_req, mem_we, mem_quad, done;
  logic [63:0] mem_addr, mem_wdata, done_data;
  logic [63:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  always #5 clk = ~clk;

  llsc_monitor dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_store_i(req_store),
    .req_fn_i(req_fn), .req_base_i(req_base), .req_disp_i(req_disp),
    .req_wdata_i(req_wdata), .busy_o(busy), .snoop_inv_i(snoop),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_quad_o(mem_quad),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready), .done_o(done), .done_data_o(done_data)
  );

  int errors = 0, checks = 0;
  int rd_cnt = 0, wr_cnt = 0, lat = 1, wait_cnt = 0;
  logic [63:0] last_addr = '0;
  logic [63:0] mem [logic [63:0]];
  bit finished = 0;

  typedef struct { logic [63:0] val; string tag; } exp_t;
  exp_t sb_q[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory responder: acts at negedge
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0;
      wait_cnt  = 0;
    end else if (mem_req) begin
      if (wait_cnt >= lat) begin
        last_addr = mem_addr;
        if (!mem.exists(mem_addr)) mem[mem_addr] = '0;
        if (mem_we) begin
          wr_cnt++;
          if (mem_quad) mem[mem_addr] = mem_wdata;
          else          mem[mem_addr] = {mem[mem_addr][63:32], mem_wdata[31:0]};
        end else begin
          rd_cnt++;
          mem_rdata = mem[mem_addr];
        end
        mem_ready = 1'b1;
      end else begin
        wait_cnt++;
      end
    end
  end

  // scoreboard monitor
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (done) begin
      chk(!prev_done, "R10 done single pulse", {63'd0, prev_done}, 64'd0);
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10 unexpected done", done_data, 64'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(done_data === e.val, e.tag, done_data, e.val);
      end
    end
    prev_done = done;
  end

  task automatic do_op(input bit st, input logic [1:0] fn, input logic [63:0] base,
                       input logic [11:0] disp, input logic [63:0] wd,
                       input logic [63:0] expv, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_fn = fn;
    req_base = base; req_disp = disp; req_wdata = wd;
    sb_q.push_back('{expv, tag});
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R10 busy after accept", {63'd0, busy}, 64'd1);
    while (sb_q.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  int rd0, wr0;

  initial begin
    mem[64'h100] = 64'h7654_3210_8000_1234;
    mem[64'h200] = 64'h0123_4567_89AB_CDEF;
    mem[64'h300] = 64'h1111_2222_7000_0005;
    mem[64'h400] = 64'h0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && mem_req === 1'b0 && done === 1'b0, "R11 reset idle",
        {61'd0, busy, mem_req, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R11: no reservation after reset
    rd0 = rd_cnt; wr0 = wr_cnt;
    do_op(1, 2'b11, 64'h100, 12'h0, 64'hDEAD, 64'd0, "R4 stc no resv status");
    chk((rd_cnt == rd0) && (wr_cnt == wr0), "R4 no memory access", 64'(rd_cnt + wr_cnt), 64'(rd0 + wr0));

    // R2 R1: plain longword load, sign extension, slower memory
    lat = 3;
    do_op(0, 2'b00, 64'hF0, 12'h010, 64'h0, 64'hFFFF_FFFF_8000_1234, "R2 long load sext");
    chk(last_addr == 64'h100, "R1 positive disp", last_addr, 64'h100);
    lat = 1;

    // R3: plain load leaves no reservation
    wr0 = wr_cnt;
    do_op(1, 2'b10, 64'h100, 12'h0, 64'h5, 64'd0, "R3 plain load no resv");
    chk(wr_cnt == wr0, "R3 no write", 64'(wr_cnt), 64'(wr0));

    // R2: quad load
    do_op(0, 2'b01, 64'h200, 12'h0, 64'h0, 64'h0123_4567_89AB_CDEF, "R2 quad load");

    // R5 success
    do_op(0, 2'b11, 64'h200, 12'h0, 64'h0, 64'h0123_4567_89AB_CDEF, "R3 locked quad load");
    do_op(1, 2'b11, 64'h200, 12'h0, 64'hAAAA_AAAA_AAAA_AAAA, 64'd1, "R5 stc match status");
    chk(mem[64'h200] == 64'hAAAA_AAAA_AAAA_AAAA, "R5 stc match write", mem[64'h200], 64'hAAAA_AAAA_AAAA_AAAA);

    // R8: reservation consumed
    wr0 = wr_cnt;
    do_op(1, 2'b11, 64'h200, 12'h0, 64'h1234, 64'd0, "R8 second stc fails");
    chk(wr_cnt == wr0, "R8 no write", 64'(wr_cnt), 64'(wr0));

    // R5 mismatch: other agent changes memory
    do_op(0, 2'b11, 64'h200, 12'h0, 64'h0, 64'hAAAA_AAAA_AAAA_AAAA, "R3 locked reload");
    mem[64'h200] = 64'hBBBB_BBBB_BBBB_BBBB;
    wr0 = wr_cnt;
    do_op(1, 2'b11, 64'h200, 12'h0, 64'hCCCC_CCCC_CCCC_CCCC, 64'd0, "R5 stc mismatch status");
    chk(wr_cnt == wr0 && mem[64'h200] == 64'hBBBB_BBBB_BBBB_BBBB, "R5 mismatch no write",
        mem[64'h200], 64'hBBBB_BBBB_BBBB_BBBB);

    // R6: longword compare ignores upper half
    do_op(0, 2'b10, 64'h300, 12'h0, 64'h0, 64'h0000_0000_7000_0005, "R2 locked long load");
    mem[64'h300] = 64'h9999_9999_7000_0005;
    do_op(1, 2'b10, 64'h300, 12'h0, 64'h5555_5555_DEAD_BEEF, 64'd1, "R6 long stc status");
    chk(mem[64'h300] == 64'h9999_9999_DEAD_BEEF, "R6 long write low half", mem[64'h300], 64'h9999_9999_DEAD_BEEF);

    // R7 R1: different address, negative displacement
    do_op(0, 2'b11, 64'h200, 12'h0, 64'h0, 64'hBBBB_BBBB_BBBB_BBBB, "R3 locked load again");
    rd0 = rd_cnt;
    do_op(1, 2'b11, 64'h408, 12'hFF8, 64'h0F0F_0F0F_0F0F_0F0F, 64'd1, "R7 other addr status");
    chk(rd_cnt == rd0, "R7 no read phase", 64'(rd_cnt), 64'(rd0));
    chk(last_addr == 64'h400, "R1 negative disp", last_addr, 64'h400);
    chk(mem[64'h400] == 64'h0F0F_0F0F_0F0F_0F0F, "R7 write done", mem[64'h400], 64'h0F0F_0F0F_0F0F_0F0F);
    wr0 = wr_cnt;
    do_op(1, 2'b11, 64'h200, 12'h0, 64'h77, 64'd0, "R8 consumed by other-addr stc");
    chk(wr_cnt == wr0, "R8 no write after consume", 64'(wr_cnt), 64'(wr0));

    // R9: snoop invalidate
    do_op(0, 2'b11, 64'h200, 12'h0, 64'h0, 64'hBBBB_BBBB_BBBB_BBBB, "R3 locked before snoop");
    @(negedge clk); snoop = 1'b1;
    @(negedge clk); snoop = 1'b0;
    rd0 = rd_cnt; wr0 = wr_cnt;
    do_op(1, 2'b11, 64'h200, 12'h0, 64'h99, 64'd0, "R9 stc after snoop");
    chk(wr_cnt == wr0 && rd_cnt == rd0, "R9 no access after snoop", 64'(wr_cnt), 64'(wr0));

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R10 watchdog expired act=%h exp=%h", 64'd0, 64'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule